// File: doc/BRIEF.md
# SPI Register-Access Bridge

This block is a serial slave that lets an external host read or write one 32-bit word at a time in an internal register space. The serial link runs in SPI mode 0 (idle clock low, data sampled on the rising edge and changed on the falling edge). An active-low select frames each transaction. The serial inputs are oversampled by the block clock through synchronizers, so the serial clock must be several times slower than the block clock.

Every frame opens with a 24-bit address field, most significant bit first. Its first bit is a write flag and its remaining 23 bits are a word index. A write frame then carries one 32-bit data word. A read frame skips a programmable number of padding bytes and then returns one 32-bit word. The padding gives slow internal registers time to answer. If the answer is late, a sticky status bit records it and the word is returned as zero.

The payload byte order and bit order can be changed at run time. The address field is never reordered. Two words at the bottom of the index space are handled locally: a control word that holds the payload order, and a config/status word that holds the padding count, the sticky flag and a fixed interface identifier. All other indices are forwarded to a request/acknowledge register port whose latency is not fixed.

Top module: `spi_regbr`

## Requirements
- R1: Serial bit 0 of a frame is the write flag (1 = write). Bits 1..23 are the word index, most significant bit first. The index is driven on `bus_addr` unchanged, whatever payload order is in force.
- R2: In a write frame, serial bits 24..55 carry the data word. After bit 55 the block performs exactly one write, with the decoded word. Further clocks in the same frame are ignored and start no second access.
- R3: In a read frame with padding count P, serial bits 24..24+8P-1 are ignored. The word is then presented on `miso` during bits 24+8P..24+8P+31, and `miso` stays 0 for any further bits (no streaming).
- R4: Payload order code O: O[0]=1 sends bytes most significant first, O[0]=0 least significant first; O[1]=1 sends each byte LSB first, O[1]=0 MSB first. Serial payload position p therefore carries word bit 8·(O[0] ? 3−p/8 : p/8) + (O[1] ? p%8 : 7−p%8).
- R5: Word index 0 is the control word: a write sets the order code to bits 1:0 of the word, decoded under the order in force before the write; a read returns the code in bits 1:0 and zeros elsewhere. A word whose every byte is {b0,b1,b0,b1,b1,b0,b1,b0} for code {b1,b0} sets that code from any prior order.
- R6: Word index 1 is the config/status word: bits 3:0 padding count P, bit 16 the late-data flag, bits 31:24 the constant 2, all other bits 0. A write stores bits 3:0 as the new P.
- R7: If the forwarded read has not been acknowledged by the time the first data bit must be presented, the late-data flag is set and the frame returns the word 0. Local reads are never late.
- R8: Writing the config/status word with bit 16 set clears the late-data flag; with bit 16 clear the flag keeps its value.
- R9: Raising the select before bit 55 of a write frame abandons it: no write is performed.
- R10: After reset the order code is 1, P is 0 and the flag is clear. `miso` is 0 whenever the select is high.
- R11: A forwarded request keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| bus_req | output | 1 | Register port request, held until acknowledged |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 23 | Word index of the request |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle completion of a request |

## Verification
The assertions assume that the serial clock half-period spans several block clocks, that `mosi` changes only together with a falling serial clock, and that `bus_ack` is a single-cycle pulse that comes only while a request is pending. They also assume that the host does not start a new forwarded access before the previous one has been acknowledged. The stimulus keeps to all of this: it holds each serial level for six clocks and moves `mosi` only at falling edges. It lets the register model pulse the acknowledge once per request after a fixed latency, and it waits longer than that latency between frames.

// File: rtl/spi_regbr_pkg.sv
package spi_regbr_pkg;

  localparam int WORD_W = 32;
  localparam logic [7:0] IF_ID = 8'd2;

  typedef logic [1:0] order_t;
  localparam order_t ORDER_RST = 2'b01;

  // Word bit carried at serial payload position p under order code ord.
  function automatic logic [4:0] slot(input order_t ord, input logic [4:0] p);
    logic [1:0] byte_sel;
    logic [2:0] bit_sel;
    byte_sel = ord[0] ? (2'd3 - p[4:3]) : p[4:3];
    bit_sel  = ord[1] ? p[2:0] : (3'd7 - p[2:0]);
    return {byte_sel, bit_sel};
  endfunction

endpackage

// File: rtl/spi_regbr_rstsync.sv
module spi_regbr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_sn = chain_q[1];
endmodule

// File: rtl/spi_regbr_sync.sv
module spi_regbr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= RST_VAL;
        else        st_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= RST_VAL;
        else        st_q[g] <= st_q[g-1];
      end
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_regbr_cfg.sv
module spi_regbr_cfg
  import spi_regbr_pkg::*;
#(
  parameter int PAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              late_set,
  output order_t            order_o,
  output logic [PAD_W-1:0]  pad_o,
  output logic              late_o
);
  order_t           order_q, order_d;
  logic [PAD_W-1:0] pad_q, pad_d;
  logic             late_q, late_d;

  always_comb begin
    order_d = order_q;
    pad_d   = pad_q;
    late_d  = late_q;
    if (ctl_we) order_d = wdata[1:0];
    if (cfg_we) begin
      pad_d = wdata[PAD_W-1:0];
      if (wdata[16]) late_d = 1'b0;
    end
    if (late_set) late_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= ORDER_RST;
      pad_q   <= '0;
      late_q  <= 1'b0;
    end else begin
      order_q <= order_d;
      pad_q   <= pad_d;
      late_q  <= late_d;
    end
  end

  assign order_o = order_q;
  assign pad_o   = pad_q;
  assign late_o  = late_q;

  // R7: the flag only rises on a late read
  a_r7_late_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> $past(late_set));
  // R8: clear request wins unless a new late event coincides
  a_r8_late_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wdata[16] && !late_set) |=> !late_q);
  // R6: padding count moves only on a config write
  a_r6_pad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(pad_q));
endmodule

// File: rtl/spi_regbr.sv
module spi_regbr
  import spi_regbr_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int PAD_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter int unsigned LOCAL_BASE = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk,
  input  logic                      cs_n,
  input  logic                      mosi,
  output logic                      miso,
  output logic                      bus_req,
  output logic                      bus_we,
  output logic [ADDR_BYTES*8-2:0]   bus_addr,
  output logic [WORD_W-1:0]         bus_wdata,
  input  logic [WORD_W-1:0]         bus_rdata,
  input  logic                      bus_ack
);
  localparam int ADDR_BITS = ADDR_BYTES * 8;
  localparam int AW = ADDR_BITS - 1;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] A_END = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] W_LAST = CNT_W'(ADDR_BITS + WORD_W - 1);
  localparam logic [AW-1:0] LBASE = AW'(LOCAL_BASE);

  logic rst_sn;
  logic s_sclk, s_csn, s_mosi;

  spi_regbr_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  spi_regbr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_sn),
    .d({sclk, cs_n, mosi}),
    .q({s_sclk, s_csn, s_mosi})
  );

  order_t           order;
  logic [PAD_W-1:0] pad;
  logic             late;
  logic             ctl_we, cfg_we, late_set;
  logic [WORD_W-1:0] cfg_wdata;

  spi_regbr_cfg #(.PAD_W(PAD_W)) u_cfg (
    .clk(clk), .rst_n(rst_sn),
    .ctl_we(ctl_we), .cfg_we(cfg_we), .wdata(cfg_wdata),
    .late_set(late_set),
    .order_o(order), .pad_o(pad), .late_o(late)
  );

  // frame state
  logic              prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [AW-1:0]     adr_q, adr_d;
  logic [WORD_W-1:0] wsh_q, wsh_d;
  logic              wgo_q, wgo_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic              miso_q, miso_d;
  logic              rdy_q, rdy_d;
  logic [WORD_W-1:0] rbuf_q, rbuf_d;
  // register port state
  logic              req_q, req_d, we_q, we_d;
  logic [AW-1:0]     badr_q, badr_d;
  logic [WORD_W-1:0] bwd_q, bwd_d;

  logic              rise, fall;
  logic [CNT_W-1:0]  dstart, dend, rel_w, rel_r;
  logic [AW-1:0]     launch_adr;
  logic [WORD_W-1:0] word_ctl, word_cfg, word_out;

  assign rise = s_sclk & ~prev_q & ~s_csn;
  assign fall = ~s_sclk & prev_q & ~s_csn;
  assign dstart = wr_q ? A_END : A_END + CNT_W'({pad, 3'b000});
  assign dend   = dstart + CNT_W'(WORD_W);
  assign rel_w  = cnt_q - A_END;
  assign rel_r  = cnt_q - dstart;
  assign launch_adr = {adr_q[AW-2:0], s_mosi};

  always_comb begin
    word_ctl = '0;
    word_ctl[1:0] = order;
    word_cfg = '0;
    word_cfg[31:24] = IF_ID;
    word_cfg[16] = late;
    word_cfg[PAD_W-1:0] = pad;
  end

  always_comb begin
    cnt_d = cnt_q;  wr_d = wr_q;  adr_d = adr_q;  wsh_d = wsh_q;
    wgo_d = 1'b0;   tx_d = tx_q;  miso_d = miso_q;
    rdy_d = rdy_q;  rbuf_d = rbuf_q;
    req_d = req_q;  we_d = we_q;  badr_d = badr_q; bwd_d = bwd_q;
    ctl_we = 1'b0;  cfg_we = 1'b0; late_set = 1'b0;
    cfg_wdata = wsh_q;
    word_out = tx_q;

    // completion of a write frame
    if (wgo_q) begin
      if (adr_q[AW-1:1] == LBASE[AW-1:1]) begin
        ctl_we = ~adr_q[0];
        cfg_we = adr_q[0];
      end else if (!req_q) begin
        req_d = 1'b1; we_d = 1'b1; badr_d = adr_q; bwd_d = wsh_q;
      end
    end

    if (s_csn) begin
      cnt_d = '0; wr_d = 1'b0; miso_d = 1'b0;
    end else begin
      if (rise) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (cnt_q == '0) begin
          wr_d  = s_mosi;
          rdy_d = 1'b0;
        end else if (cnt_q < A_END) begin
          adr_d = launch_adr;
        end
        if (wr_q && cnt_q >= A_END && cnt_q <= W_LAST)
          wsh_d[slot(order, rel_w[4:0])] = s_mosi;
        if (wr_q && cnt_q == W_LAST) wgo_d = 1'b1;
        if (!wr_q && cnt_q == A_END - 1'b1) begin
          if (launch_adr[AW-1:1] == LBASE[AW-1:1]) begin
            rbuf_d = launch_adr[0] ? word_cfg : word_ctl;
            rdy_d  = 1'b1;
          end else if (!req_q) begin
            req_d = 1'b1; we_d = 1'b0; badr_d = launch_adr;
          end
        end
      end
      if (fall) begin
        if (!wr_q && cnt_q >= dstart && cnt_q < dend) begin
          if (cnt_q == dstart) begin
            word_out = rdy_q ? rbuf_q : '0;
            late_set = ~rdy_q;
            tx_d = word_out;
          end
          miso_d = word_out[slot(order, rel_r[4:0])];
        end else begin
          miso_d = 1'b0;
        end
      end
    end

    if (req_q && bus_ack) begin
      req_d = 1'b0;
      if (!we_q) begin
        rbuf_d = bus_rdata;
        rdy_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      prev_q <= 1'b0; cnt_q <= '0; wr_q <= 1'b0; adr_q <= '0; wsh_q <= '0;
      wgo_q <= 1'b0; tx_q <= '0; miso_q <= 1'b0; rdy_q <= 1'b0; rbuf_q <= '0;
      req_q <= 1'b0; we_q <= 1'b0; badr_q <= '0; bwd_q <= '0;
    end else begin
      prev_q <= s_sclk; cnt_q <= cnt_d; wr_q <= wr_d; adr_q <= adr_d; wsh_q <= wsh_d;
      wgo_q <= wgo_d; tx_q <= tx_d; miso_q <= miso_d; rdy_q <= rdy_d; rbuf_q <= rbuf_d;
      req_q <= req_d; we_q <= we_d; badr_q <= badr_d; bwd_q <= bwd_d;
    end
  end

  assign miso      = miso_q;
  assign bus_req   = req_q;
  assign bus_we    = we_q;
  assign bus_addr  = badr_q;
  assign bus_wdata = bwd_q;

  // R11: a pending request does not move until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_q && !bus_ack) |=> (req_q && $stable(badr_q) && $stable(bwd_q) && $stable(we_q)));
  // R10: no data is driven while deselected
  a_r10_miso_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    s_csn |=> !miso_q);
  // R2: a write frame completes at most once
  a_r2_single_go: assert property (@(posedge clk) disable iff (!rst_sn)
    wgo_q |=> !wgo_q);
  // R9: completion needs the select held through the last data bit
  a_r9_go_selected: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(wgo_q) |-> $past(!s_csn));
endmodule

// File: tb/spi_regbr_bench.sv
module spi_regbr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int LAT = 30;

  logic clk, rst_n, sclk, cs_n, mosi, miso;
  logic bus_req, bus_we, bus_ack;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_chk, n_err, nwr, r11_bad, lat_cnt, last_wa;
  logic [31:0] last_wd;
  logic [31:0] mem [16];
  logic [22:0] hold_a;
  logic [31:0] hold_d;
  bit done;
  int cur_order, cur_pad;

  spi_regbr u_spi_regbr (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // register port model with fixed latency
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; lat_cnt <= 0; bus_rdata <= '0;
      for (int k = 0; k < 16; k++) mem[k] <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (lat_cnt == 0) begin hold_a <= bus_addr; hold_d <= bus_wdata; end
        else if (bus_addr != hold_a || (bus_we && bus_wdata != hold_d)) r11_bad <= r11_bad + 1;
        if (lat_cnt == LAT) begin
          bus_ack <= 1'b1; lat_cnt <= 0;
          if (bus_we) begin
            mem[bus_addr[3:0]] <= bus_wdata;
            nwr <= nwr + 1; last_wa <= int'(bus_addr); last_wd <= bus_wdata;
          end else bus_rdata <= mem[bus_addr[3:0]];
        end else lat_cnt <= lat_cnt + 1;
      end
    end
  end

  function automatic int slot_of(int ord, int p);
    int bi, bt;
    bi = (ord % 2 == 1) ? 3 - p / 8 : p / 8;
    bt = (ord / 2 == 1) ? p % 8 : 7 - p % 8;
    return bi * 8 + bt;
  endfunction

  function automatic logic [31:0] rep_word(int c);
    logic [7:0] b;
    logic b1, b0;
    b1 = c[1]; b0 = c[0];
    b = {b0, b1, b0, b1, b1, b0, b1, b0};
    return {b, b, b, b};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input int idx, input logic [31:0] wd, input int nbits,
                      output logic [31:0] rd, output bit tail_nz);
    int ds;
    logic [22:0] ia;
    ia = 23'(idx);
    ds = wr ? 24 : 24 + 8 * cur_pad;
    rd = '0; tail_nz = 1'b0;
    @(negedge clk); cs_n = 1'b0; sclk = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (i == 0) mosi = wr;
      else if (i < 24) mosi = ia[23 - i];
      else if (wr && i < 56) mosi = wd[slot_of(cur_order, i - 24)];
      else mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      if (!wr && i >= ds && i < ds + 32) rd[slot_of(cur_order, i - ds)] = miso;
      if (!wr && i >= ds + 32 && miso) tail_nz = 1'b1;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    repeat (LAT + 20) @(negedge clk);
  endtask

  task automatic wr_word(int idx, logic [31:0] wd);
    logic [31:0] d; bit t;
    xfer(1'b1, idx, wd, 56, d, t);
  endtask

  task automatic rd_word(int idx, output logic [31:0] rd);
    bit t;
    xfer(1'b0, idx, '0, 24 + 8 * cur_pad + 32, rd, t);
  endtask

  function automatic logic [31:0] cfg_exp(bit late, int pad);
    return {8'd2, 7'd0, late, 12'd0, 4'(pad)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, pat;
    bit tail;
    int base;
    done = 1'b0; n_chk = 0; n_err = 0; nwr = 0; r11_bad = 0;
    cur_order = 1; cur_pad = 0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R10 miso idle", 32'(miso), 0);
    chk("R10 no request", 32'(bus_req), 0);
    rd_word(1, rd); chk("R6 R10 cfg default", rd, cfg_exp(0, 0));
    rd_word(0, rd); chk("R5 R10 ctl default", rd, 32'd1);

    wr_word(1, 32'd2); cur_pad = 2;
    rd_word(1, rd); chk("R6 cfg pad write", rd, cfg_exp(0, 2));

    // sweep every order code from different predecessors
    for (int s = 0; s < 4; s++) begin
      int c;
      c = (s * 3 + 2) % 4;
      wr_word(0, rep_word(c)); cur_order = c;
      rd_word(0, rd); chk("R5 order readback", rd, 32'(c));
      for (int k = 0; k < 4; k++) begin
        base = 16 + c * 4 + k;
        pat = 32'h8143_C2A5 ^ (32'(base) * 32'h0103_0507) ^ {24'd0, 8'(k << 5)};
        wr_word(base, pat);
        chk("R1 bus index", 32'(last_wa), 32'(base));
        chk("R2 R4 write word", last_wd, pat);
        xfer(1'b0, base, '0, 24 + 8 * cur_pad + 64, rd, tail);
        chk("R3 R4 read word", rd, pat);
        chk("R3 no streaming", 32'(tail), 0);
      end
    end

    // extra clocks after a write
    base = nwr;
    xfer(1'b1, 20, 32'hDEAD_BEEF, 56 + 24, rd, tail);
    chk("R2 single write", 32'(nwr), 32'(base + 1));
    // abandoned write
    xfer(1'b1, 20, 32'h1234_5678, 40, rd, tail);
    chk("R9 no write count", 32'(nwr), 32'(base + 1));
    rd_word(20, rd); chk("R9 value kept", rd, 32'hDEAD_BEEF);

    // padding sweep against the fixed latency
    for (int p = 0; p < 4; p++) begin
      wr_word(1, 32'h0001_0000 | 32'(p)); cur_pad = p;
      rd_word(20, rd);
      chk("R7 late read data", rd, (p == 0) ? 32'd0 : 32'hDEAD_BEEF);
      rd_word(1, rd); chk("R7 late flag", rd, cfg_exp(p == 0, p));
    end
    wr_word(1, 32'd0); cur_pad = 0;
    rd_word(20, rd);
    wr_word(1, 32'd3); cur_pad = 3;
    rd_word(1, rd); chk("R8 flag kept", rd, cfg_exp(1, 3));
    wr_word(1, 32'h0001_0003);
    rd_word(1, rd); chk("R8 flag cleared", rd, cfg_exp(0, 3));

    chk("R11 request steady", 32'(r11_bad), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule